// File: doc/BRIEF.md
# Trigger Timestamp Capture Unit

This block records the time of day at which external trigger signals rise. Two independent trigger inputs, possibly asynchronous to the core clock, are passed through a two-flop synchroniser. On each synchronised rising edge the 64-bit time value presented on `time_now` is stored in that channel's capture store. Depending on a mode pin, the store is either a small first-in first-out queue or a single slot that always holds the newest stamp.

Software reaches the block through a simple single-cycle register port. It reads each stamp as a low word followed by a high word, and the high-word read removes the entry. A status word shows which channels still hold entries, so a driver can drain a channel by reading pairs until its bit clears. An event word gathers the two capture events and a pulse-per-second event. Bits in the event word are cleared by writing ones, and each event has a mask bit. The masked events are combined into one interrupt line.

The register port is always ready and applies no back-pressure. A read strobe in one cycle yields `reg_rdata` after the next rising clock edge, and the value is held until the next read. A write takes effect at the clock edge that samples it. The trigger path also applies no back-pressure: in queue mode a capture that finds its queue full is discarded.

Top module: `trig_stamp_unit`

## Requirements
- R1: After reset both capture stores are empty, the event and mask words are 0, `irq_out` is 0, `reg_rdata` is 0 and every address reads 0.
- R2: A rising edge on `trig_in[c]` is captured once, even if the input stays high, storing the `time_now` value sampled on the third rising clock edge after the input rises (two synchroniser flops plus edge detection).
- R3: With `fifo_mode`=1 each channel keeps up to DEPTH stamps in arrival order. A read of address 0 (channel 0) or 2 (channel 1) returns bits 31:0 of the oldest entry and latches its bits 63:32. A read of address 1 or 3 returns the latched high half and removes that entry.
- R4: With `fifo_mode`=1, a capture arriving when the channel already holds DEPTH entries is discarded, and the stored entries are unchanged.
- R5: With `fifo_mode`=0 a channel holds one stamp. A new capture replaces it, and a high-half read empties the channel.
- R6: The event word at address 4 has bit 0 for a channel 0 capture, bit 1 for a channel 1 capture and bit 2 for a cycle with `pps_in` high. A bit is set by its event and cleared by writing 1 to it. Writing 0 leaves the bit unchanged, and a set in the same cycle wins over a clear.
- R7: The mask word at address 5 (bits 2:0) is read/write. `irq_out` is high exactly when some event bit and its mask bit are both 1.
- R8: Address 6 returns the status word, with bit 0 set while channel 0 holds entries and bit 1 for channel 1. Address 7 reads 0. A low-half read of an empty channel returns 0 and latches 0 as the high half.
- R9: The two channels are independent. Simultaneous triggers store the same time in both channels, and reads of one channel do not disturb the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time value to be stamped |
| trig_in | input | 2 | Asynchronous trigger inputs, one per channel |
| pps_in | input | 1 | Synchronous pulse-per-second event, one cycle high |
| fifo_mode | input | 1 | 1 = queue of DEPTH entries, 0 = single newest stamp |
| reg_addr | input | 3 | Register word address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_out | output | 1 | Masked event interrupt |

## Verification
The hardest case to reach from the ports is the drop on a full queue. A capture must land while a channel already holds DEPTH entries, and the bench must then show that the stored entries were not shifted or overwritten. The bench fires DEPTH+2 triggers on one channel without reading in between, then drains the channel and compares every stamp with the first DEPTH times. A random phase interleaves captures on either or both channels with pair reads. A bench model of both queues, including the discard rule, supplies the expected values.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int STAMP_W = 64;
  localparam int WORD_W  = 32;
  localparam int N_CH    = 2;
  localparam int N_EVT   = 3;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_C0_LO  = 3'd0,
    ADR_C0_HI  = 3'd1,
    ADR_C1_LO  = 3'd2,
    ADR_C1_HI  = 3'd3,
    ADR_EVENT  = 3'd4,
    ADR_MASK   = 3'd5,
    ADR_STATUS = 3'd6,
    ADR_SPARE  = 3'd7
  } reg_addr_e;

  localparam int EVT_PPS = 2;
endpackage

// File: rtl/ts_sync_edge.sv
module ts_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], async_in};
  end

  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

  // R2: one input edge yields exactly one single-cycle capture strobe
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ts_stamp_fifo.sv
module ts_stamp_fifo
  import ts_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic               cap_stb,
  input  logic [STAMP_W-1:0] cap_time,
  input  logic               rd_lo,
  input  logic               rd_hi,
  output logic [WORD_W-1:0]  lo_word,
  output logic [WORD_W-1:0]  hi_word,
  output logic               not_empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [STAMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic [WORD_W-1:0]  hi_shadow;
  logic               empty, full, accept, pop, single_wr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign single_wr = !fifo_mode && cap_stb;
  assign accept    = fifo_mode && cap_stb && !full;
  assign pop       = rd_hi && !empty && !single_wr;

  always_ff @(posedge clk) begin
    if (single_wr)   mem[rd_ptr] <= cap_time;
    else if (accept) mem[wr_ptr] <= cap_time;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (single_wr) begin
      wr_ptr <= ptr_next(rd_ptr);
      count  <= CNT_W'(1);
    end else begin
      if (accept) wr_ptr <= ptr_next(wr_ptr);
      if (pop)    rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(accept) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_shadow <= '0;
    else if (rd_lo) hi_shadow <= empty ? '0 : mem[rd_ptr][STAMP_W-1:WORD_W];
  end

  assign lo_word   = empty ? '0 : mem[rd_ptr][WORD_W-1:0];
  assign hi_word   = hi_shadow;
  assign not_empty = !empty;

  // R4: occupancy never exceeds the queue depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R4: a capture into a full queue leaves occupancy unchanged
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && cap_stb && full && !rd_hi) |=> (count == $past(count)));
  // R3: a high-half read removes exactly one entry
  a_r3_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rd_hi && !empty && !cap_stb) |=> (count == $past(count) - 1'b1));
  // R5: single-slot mode holds exactly one stamp after a capture
  a_r5_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && cap_stb) |=> (count == CNT_W'(1)));
endmodule

// File: rtl/ts_event_ctrl.sv
module ts_event_ctrl
  import ts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_set,
  input  logic             wr_evt,
  input  logic             wr_mask,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] evt_q,
  output logic [N_EVT-1:0] mask_q,
  output logic             irq_out
);
  logic [N_EVT-1:0] clr;

  assign clr = wr_evt ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr) | evt_set;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign irq_out = |(evt_q & mask_q);

  // R6: a write of ones clears those bits unless an event sets them
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ((wdata & evt_set) == '0)) |=> ((evt_q & $past(wdata)) == '0));
  // R6: every event leaves its bit set
  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));
  // R6: with no event and no write the event word holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && (evt_set == '0)) |=> $stable(evt_q));
  // R7: a cleared mask keeps the interrupt low
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out);
endmodule

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit
  import ts_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAMP_W-1:0] time_now,
  input  logic [N_CH-1:0]    trig_in,
  input  logic               pps_in,
  input  logic               fifo_mode,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               irq_out
);
  logic [N_CH-1:0]   cap_rise;
  logic [N_CH-1:0]   ch_avail;
  logic [WORD_W-1:0] ch_lo [N_CH];
  logic [WORD_W-1:0] ch_hi [N_CH];
  logic [N_EVT-1:0]  evt_q, mask_q;
  logic [WORD_W-1:0] rd_mux;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic rd_lo_c, rd_hi_c;

    assign rd_lo_c = reg_rd && (reg_addr == ADDR_W'(2 * c));
    assign rd_hi_c = reg_rd && (reg_addr == ADDR_W'(2 * c + 1));

    ts_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_in[c]),
      .rise     (cap_rise[c])
    );

    ts_stamp_fifo #(.DEPTH(DEPTH)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_mode (fifo_mode),
      .cap_stb   (cap_rise[c]),
      .cap_time  (time_now),
      .rd_lo     (rd_lo_c),
      .rd_hi     (rd_hi_c),
      .lo_word   (ch_lo[c]),
      .hi_word   (ch_hi[c]),
      .not_empty (ch_avail[c])
    );
  end

  ts_event_ctrl i_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_set ({pps_in, cap_rise}),
    .wr_evt  (reg_wr && (reg_addr == ADR_EVENT)),
    .wr_mask (reg_wr && (reg_addr == ADR_MASK)),
    .wdata   (reg_wdata[N_EVT-1:0]),
    .evt_q   (evt_q),
    .mask_q  (mask_q),
    .irq_out (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_C0_LO:  rd_mux = ch_lo[0];
      ADR_C0_HI:  rd_mux = ch_hi[0];
      ADR_C1_LO:  rd_mux = ch_lo[1];
      ADR_C1_HI:  rd_mux = ch_hi[1];
      ADR_EVENT:  rd_mux = WORD_W'(evt_q);
      ADR_MASK:   rd_mux = WORD_W'(mask_q);
      ADR_STATUS: rd_mux = WORD_W'(ch_avail);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R8: the spare address always reads zero
  a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_SPARE) |=> (reg_rdata == '0));
  // R2: a capture strobe always raises its channel's event bit
  a_r2_evt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise[0] |=> evt_q[0]);
endmodule

// File: tb/test_trig_stamp_unit.sv
`timescale 1ns/1ps
module test_trig_stamp_unit;
  localparam int DEPTH = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] time_now = '0;
  logic [1:0]  trig_in = '0;
  logic        pps_in = 0;
  logic        fifo_mode = 1;
  logic [2:0]  reg_addr = '0;
  logic        reg_rd = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [63:0] q0[$];
  logic [63:0] q1[$];

  always #5 clk = ~clk;

  trig_stamp_unit #(.DEPTH(DEPTH)) i_trig_stamp_unit (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .trig_in(trig_in),
    .pps_in(pps_in), .fifo_mode(fifo_mode), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_pair(input int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'(2 * ch), lo);
    rd(3'(2 * ch + 1), hi);
    v = {hi, lo};
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic void model_cap(input logic [1:0] chs, input logic [63:0] t);
    if (chs[0]) begin
      if (!fifo_mode) q0.delete();
      if (q0.size() < DEPTH) q0.push_back(t);
    end
    if (chs[1]) begin
      if (!fifo_mode) q1.delete();
      if (q1.size() < DEPTH) q1.push_back(t);
    end
  endfunction

  task automatic fire(input logic [1:0] chs, input logic [63:0] t, input int hold);
    @(negedge clk); time_now = t; trig_in = chs;
    repeat (hold) @(negedge clk);
    trig_in = '0;
    repeat (5) @(negedge clk);
    model_cap(chs, t);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] s;
    rd(3'd6, s);
    chk(s == {30'd0, q1.size() != 0, q0.size() != 0}, tag, 64'(s),
        64'({q1.size() != 0, q0.size() != 0}));
  endtask

  task automatic drain_check(input int ch, input string tag);
    logic [63:0] v, e;
    e = (ch == 0) ? q0.pop_front() : q1.pop_front();
    rd_pair(ch, v);
    chk(v == e, tag, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, t;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(irq_out == 0, "R1 irq after reset", 64'(irq_out), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register reads zero", 64'(d), 0);
    end

    // R2 R3: three captures in order
    for (int i = 0; i < 3; i++) fire(2'b01, rnd64(), 1);
    check_status("R3 status while entries remain");
    for (int i = 0; i < 3; i++) drain_check(0, "R3 ordered stamp");
    check_status("R3 status after drain");

    // R2: long high level captures once
    t = rnd64();
    fire(2'b01, t, 12);
    chk(q0.size() == 1, "R2 model single entry", q0.size(), 1);
    drain_check(0, "R2 held trigger stamp");
    check_status("R2 only one entry");

    // R4: overflow drops newer captures
    for (int i = 0; i < DEPTH + 2; i++) fire(2'b10, rnd64(), 2);
    check_status("R4 full status");
    for (int i = 0; i < DEPTH; i++) drain_check(1, "R4 kept entry");
    check_status("R4 empty after DEPTH pops");

    // R9: simultaneous triggers
    t = rnd64();
    fire(2'b11, t, 1);
    check_status("R9 both channels filled");
    drain_check(1, "R9 channel 1 stamp");
    check_status("R9 channel 0 untouched");
    drain_check(0, "R9 channel 0 stamp");

    // R5: single-slot mode keeps the newest
    fifo_mode = 0;
    fire(2'b01, rnd64(), 1);
    fire(2'b01, rnd64(), 1);
    check_status("R5 one stamp held");
    drain_check(0, "R5 newest stamp");
    check_status("R5 empty after high read");
    fifo_mode = 1;

    // R6: event word behaviour
    wr(3'd4, 32'h7);
    rd(3'd4, d);
    chk(d == 0, "R6 cleared events", 64'(d), 0);
    fire(2'b10, rnd64(), 1);
    rd(3'd4, d);
    chk(d == 2, "R6 channel 1 event", 64'(d), 2);
    wr(3'd4, 32'h0);
    rd(3'd4, d);
    chk(d == 2, "R6 write zero no effect", 64'(d), 2);
    @(negedge clk); pps_in = 1;
    @(negedge clk); pps_in = 0;
    rd(3'd4, d);
    chk(d == 6, "R6 pps event", 64'(d), 6);
    wr(3'd4, 32'h2);
    rd(3'd4, d);
    chk(d == 4, "R6 w1c single bit", 64'(d), 4);

    // R7: mask and interrupt
    wr(3'd5, 32'h4);
    rd(3'd5, d);
    chk(d == 4, "R7 mask readback", 64'(d), 4);
    chk(irq_out == 1, "R7 irq masked pps", 64'(irq_out), 1);
    wr(3'd5, 32'h1);
    chk(irq_out == 0, "R7 irq other bit masked", 64'(irq_out), 0);
    wr(3'd4, 32'h4);
    wr(3'd5, 32'h4);
    chk(irq_out == 0, "R7 irq after ack", 64'(irq_out), 0);
    wr(3'd5, 32'h0);

    // R8: spare address and empty channel reads
    drain_check(1, "R8 flush leftover");
    rd(3'd7, d);
    chk(d == 0, "R8 spare address", 64'(d), 0);
    rd_pair(0, v);
    chk(v == 0, "R8 empty channel pair", v, 0);

    // R9 R3 R4: random interleaving
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: fire(2'b01, rnd64(), 1);
        1: fire(2'b10, rnd64(), 1);
        2: fire(2'b11, rnd64(), 1);
        default: begin
          int ch;
          ch = $urandom_range(0, 1);
          if ((ch == 0 && q0.size() != 0) || (ch == 1 && q1.size() != 0))
            drain_check(ch, "R9 random stamp");
          check_status("R9 random status");
        end
      endcase
    end
    while (q0.size() != 0) drain_check(0, "R9 final drain ch0");
    while (q1.size() != 0) drain_check(1, "R9 final drain ch1");
    check_status("R9 both empty");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule